// File: doc/BRIEF.md
# Burst Column Sequencer

This block produces the column address sequence for a single read or write burst toward a synchronous DRAM. A mode-load cycle stores a burst length code and a wrap-order bit. After that, a start pulse with a starting column makes the block emit one column per clock. Each column comes with a valid flag, and the final beat of the burst also raises a last flag.

Wrapping stays inside the aligned block whose size equals the burst length. In sequential order the low bits count upward modulo the length. In interleaved order the low bits are the start's low bits XOR the beat index. A start pulse may arrive on any clock, and it cuts off whatever burst is running, so the controller can issue a fresh random column every cycle.

The controller is a two-state machine. IDLE moves to RUN on a start pulse (transition GO). RUN holds on a non-final beat (transition STEP). RUN restarts on a start pulse (transition RESTART). RUN returns to IDLE after the last beat when no start is present (transition DONE). A mode load is accepted only in IDLE.

Top module: `burst_col_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the next state has beat_vld=0, burst length 1 and sequential order.
- R2: A mode load with blen_code 0/1/2/3 selects a burst of 1/2/4/8 beats. With wrap_il=0 the order is sequential and with wrap_il=1 it is interleaved. A mode load is ignored while a burst is running.
- R3: A start pulse at edge k gives beat 0 (col = start column) with beat_vld=1 in the cycle after edge k. Beats follow on consecutive cycles.
- R4: In sequential order, beat n has low log2(BL) bits equal to (start_low + n) mod BL. The upper bits equal those of the start column.
- R5: In interleaved order, beat n has low log2(BL) bits equal to start_low XOR n. The upper bits equal those of the start column.
- R6: beat_last is 1 on exactly beat BL-1. With BL=1 a single beat is produced, and it is flagged last.
- R7: A start pulse during a burst discards the remainder of that burst, and the new burst's beat 0 appears on the next cycle.
- R8: With no start pulse, beat_vld falls to 0 in the cycle after the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Load burst length and wrap order |
| blen_code | input | 2 | Burst length code: 0=1, 1=2, 2=4, 3=8 beats |
| wrap_il | input | 1 | 0 sequential, 1 interleaved |
| start | input | 1 | Begin a burst (pre-empts a running one) |
| start_col | input | COL_W | Starting column |
| col | output | COL_W | Current column address |
| beat_vld | output | 1 | col holds a valid beat |
| beat_last | output | 1 | Final beat of the burst |

## Verification
The bench builds the block with COL_W=5, so the 32 starting columns cover every upper-bit pattern above the widest 3-bit wrap field. It sweeps all 32 start columns against all four burst lengths in both orders and checks every beat arithmetically. That sweep reaches each wrap point and every XOR pattern. Separate runs place a restart at every beat position of an 8-beat burst, try a mode load during a burst, and confirm the idle gap after a burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_IL  = 1'b1
    } wrap_ord_t;

    localparam int MAX_LG = 3;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
    import burst_col_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_en,
    input  logic [1:0] code_in,
    input  logic       il_in,
    output logic [1:0] code_q,
    output wrap_ord_t  ord_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= 2'd0;
            ord_q  <= ORD_SEQ;
        end else if (ld_en) begin
            code_q <= code_in;
            ord_q  <= wrap_ord_t'(il_in);
        end
    end

    // R1
    reset_mode_chk: assert property (@(posedge clk)
        !rst_n |=> (code_q == 2'd0 && ord_q == ORD_SEQ));
endmodule

// File: rtl/burst_col_math.sv
module burst_col_math
    import burst_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0]  base_col,
    input  logic [MAX_LG-1:0] beat_idx,
    input  logic [1:0]        code,
    input  wrap_ord_t         ord,
    output logic [COL_W-1:0]  col_out
);
    logic [MAX_LG-1:0] low_base;
    logic [MAX_LG-1:0] low_new;
    logic [MAX_LG-1:0] keep_mask;

    always_comb begin
        low_base  = base_col[MAX_LG-1:0];
        keep_mask = MAX_LG'((1 << code) - 1);
        if (ord == ORD_IL)
            low_new = low_base ^ beat_idx;
        else
            low_new = low_base + beat_idx;
        col_out = base_col;
        col_out[MAX_LG-1:0] = (low_base & ~keep_mask) | (low_new & keep_mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ld,
    input  logic [1:0]       blen_code,
    input  logic             wrap_il,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] col,
    output logic             beat_vld,
    output logic             beat_last
);
    localparam int IDX_W = MAX_LG;

    seq_state_t        state_q, state_d;
    logic [1:0]        code_q;
    wrap_ord_t         ord_q;
    logic [COL_W-1:0]  base_q, base_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [IDX_W-1:0]  final_idx;
    logic              at_final;

    burst_mode_reg i_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (mode_ld && state_q == ST_IDLE && !start),
        .code_in (blen_code),
        .il_in   (wrap_il),
        .code_q  (code_q),
        .ord_q   (ord_q)
    );

    burst_col_math #(.COL_W(COL_W)) i_math (
        .base_col (base_q),
        .beat_idx (idx_q),
        .code     (code_q),
        .ord      (ord_q),
        .col_out  (col)
    );

    assign final_idx = IDX_W'((1 << code_q) - 1);
    assign at_final  = (idx_q == final_idx);

    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUN;
                    base_d  = start_col;
                    idx_d   = '0;
                end
            end
            ST_RUN: begin
                if (start) begin
                    base_d = start_col;
                    idx_d  = '0;
                end else if (at_final) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        beat_vld  = (state_q == ST_RUN);
        beat_last = (state_q == ST_RUN) && at_final;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !beat_vld);

    // R3
    start_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_vld && col == $past(start_col)));

    // R8
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_vld);

    // R6
    one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && code_q == 2'd0) |-> beat_last);

    // R4
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_vld && !$past(start) && $past(beat_vld)) |-> (col[COL_W-1:IDX_W] == $past(col[COL_W-1:IDX_W])));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld |=> $stable(code_q));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_ld = 1'b0;
    logic [1:0]    blen_code = 2'd0;
    logic          wrap_il = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] start_col = '0;
    logic [CW-1:0] col;
    logic          beat_vld, beat_last;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    burst_col_seq #(.COL_W(CW)) i_burst_col_seq (
        .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .blen_code(blen_code),
        .wrap_il(wrap_il), .start(start), .start_col(start_col),
        .col(col), .beat_vld(beat_vld), .beat_last(beat_last)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_col(int s, int bl, bit il, int n);
        int lo = s % bl;
        int hi = s - lo;
        return il ? hi + (lo ^ n) : hi + ((lo + n) % bl);
    endfunction

    task automatic set_mode(input int code, input bit il);
        @(negedge clk);
        mode_ld = 1'b1; blen_code = code[1:0]; wrap_il = il;
        @(negedge clk);
        mode_ld = 1'b0;
    endtask

    // pulse start in this negedge window; then check each beat
    task automatic run_burst(input int s, input int code, input bit il, input string req);
        int bl = 1 << code;
        start = 1'b1; start_col = s[CW-1:0];
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < bl; n++) begin
            chk(req, int'(col), exp_col(s, bl, il, n));
            chk("R3", int'(beat_vld), 1);
            chk("R6", int'(beat_last), (n == bl - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk("R8", int'(beat_vld), 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        chk("R1", int'(beat_vld), 0);
        rst_n = 1'b1;
        // R1: default BL=1, sequential
        run_burst(13, 0, 1'b0, "R1");
        for (int code = 0; code < 4; code++) begin
            for (int il = 0; il < 2; il++) begin
                set_mode(code, il[0]);
                for (int s = 0; s < 32; s++)
                    run_burst(s, code, il[0], il ? "R5" : "R4");
            end
        end
        // R7: restart at each beat of an 8-beat sequential burst
        set_mode(3, 1'b0);
        for (int k = 0; k < 8; k++) begin
            start = 1'b1; start_col = 5'd10;
            @(negedge clk);
            start = 1'b0;
            for (int n = 0; n < k; n++) @(negedge clk);
            chk("R7", int'(col), exp_col(10, 8, 1'b0, k));
            run_burst(21, 3, 1'b0, "R7");
        end
        // R2: mode load during burst ignored
        set_mode(2, 1'b1);
        start = 1'b1; start_col = 5'd6;
        @(negedge clk);
        start = 1'b0; mode_ld = 1'b1; blen_code = 2'd0; wrap_il = 1'b0;
        @(negedge clk);
        mode_ld = 1'b0;
        chk("R2", int'(beat_vld), 1);
        chk("R2", int'(col), exp_col(6, 4, 1'b1, 1));
        @(negedge clk); @(negedge clk); @(negedge clk);
        run_burst(9, 2, 1'b1, "R2");
        // R1: reset mid-burst
        start = 1'b1; start_col = 5'd3;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1", int'(beat_vld), 0);
        run_burst(7, 0, 1'b0, "R1");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_vec++; n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule